// File: doc/BRIEF.md
# Speculative Predicate Issue and Check Unit

This unit sits next to an instruction queue and manages guessed predicate values for the one instruction block currently held there. When a block is loaded, it captures a guessed-value bitmap and a trust bitmap, with one bit of each per predicate-producing test instruction. Every trusted guess is handed to the consuming instructions at once, so they can run before their test operands arrive. Untrusted predicates are not guessed, and their consumers wait for the real test outcome.

The test instructions still execute. When a real outcome arrives, the unit compares it with the stored guess. For an untrusted predicate, it forwards the outcome. For a trusted predicate whose guess was right, it drops the outcome so that consumers never see a value twice. For a trusted predicate whose guess was wrong, it raises a one-cycle misspeculation pulse. That pulse requests a flush of this block and its dependents, carries the true outcome for the predictor update, and switches the unit into a safe mode. In safe mode, the refetched block runs with all guessing disabled. Safe mode lasts until a block commits.

Top module: `psv_unit`

## Requirements
- R1: During synchronous active-high reset and on the first cycle after it, `del_valid`, `del_value`, `flush_req`, `upd_valid`, `upd_idx`, `upd_value` and `nospec_mode` are all 0.
- R2: A load, when neither commit nor flush is asserted and safe mode is off, gives `del_valid == load_conf` and `del_value == load_pred & load_conf` on the following cycle. Bit i of each vector belongs to predicate i.
- R3: A real outcome on `res_idx` for a loaded, unresolved, untrusted predicate gives `del_valid` one-hot at bit `res_idx` on the next cycle. `del_value` carries the outcome at that bit and 0 elsewhere.
- R4: A real outcome that matches the guess of a trusted predicate produces no delivery and no flush request.
- R5: A real outcome that differs from the guess of a trusted predicate produces a one-cycle pulse of `flush_req` and `upd_valid` on the next cycle. In that cycle, `upd_idx` and `upd_value` equal the predicate index and its true outcome. Outside such a pulse, all four are 0.
- R6: After a misspeculation, `nospec_mode` is 1. Loads made in safe mode deliver nothing, whatever `load_conf` holds. In safe mode, every real outcome is forwarded as in R3.
- R7: `nospec_mode` stays 1 until `blk_commit` is asserted. It is 0 on the cycle after the commit.
- R8: `blk_commit`, `blk_flush` and a misspeculation clear all stored predicate state. Real outcomes that arrive afterwards, before the next load, produce no output.
- R9: A second real outcome for a predicate that has already been resolved produces no output.
- R10: Commit and flush take priority over a load, and a load takes priority over a real outcome. An outcome that arrives in the same cycle as a load or a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_load | input | 1 | Capture the bitmaps for a newly fetched block |
| load_pred | input | NUM_PRED | Guessed predicate values, one bit per test instruction |
| load_conf | input | NUM_PRED | Trust bits; 1 means the guess is issued early |
| res_valid | input | 1 | A test instruction produced its real outcome |
| res_idx | input | IDX_W | Index of the predicate that resolved |
| res_value | input | 1 | Real outcome of that predicate |
| blk_commit | input | 1 | Block committed; clears state and leaves safe mode |
| blk_flush | input | 1 | Block flushed from outside; clears state |
| del_valid | output | NUM_PRED | Per-predicate delivery strobe to consumers |
| del_value | output | NUM_PRED | Delivered predicate values, 0 where not strobed |
| flush_req | output | 1 | Misspeculation: flush this block and its dependents |
| upd_valid | output | 1 | Predictor update strobe |
| upd_idx | output | IDX_W | Predicate index for the update |
| upd_value | output | 1 | True outcome for the update |
| nospec_mode | output | 1 | Safe mode: predicate guessing disabled |

## Verification
The first load pattern mixes trusted and untrusted bits with both polarities. This shows that only trusted bits drive early and that each carries its own guessed value. Outcomes are then fed in four kinds: untrusted, trusted and matching, trusted and conflicting, and repeated. This separates forwarding from suppression, misspeculation and the handling of a predicate that is already resolved. Safe mode is tried with an all-ones trust bitmap and with a contradicting outcome, to show that guessing is fully off and that no second flush occurs. Collision cycles (outcome with load, outcome with flush, commit with load) confirm the priority order.

// File: rtl/psv_pkg.sv
package psv_pkg;
  typedef enum logic {
    MODE_SPEC   = 1'b0,
    MODE_NOSPEC = 1'b1
  } psv_mode_e;
endpackage

// File: rtl/psv_slot.sv
module psv_slot (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ld,
  input  logic ld_pred,
  input  logic ld_spec,
  input  logic hit,
  output logic loaded,
  output logic pred,
  output logic spec,
  output logic done
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      loaded <= 1'b0;
      pred   <= 1'b0;
      spec   <= 1'b0;
      done   <= 1'b0;
    end else if (ld) begin
      loaded <= 1'b1;
      pred   <= ld_pred;
      spec   <= ld_spec;
      done   <= 1'b0;
    end else if (hit && loaded) begin
      done <= 1'b1;
    end
  end

  AST_SLOT_SPEC_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    spec |-> loaded); // R2
  AST_SLOT_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done && !clr && !ld |=> done); // R9
endmodule

// File: rtl/psv_mode.sv
module psv_mode
  import psv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic commit,
  input  logic mis,
  output logic nospec
);
  psv_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst || commit)
      mode_q <= MODE_SPEC;
    else if (mis)
      mode_q <= MODE_NOSPEC;
  end

  assign nospec = (mode_q == MODE_NOSPEC);

  AST_MODE_COMMIT_EXITS: assert property (@(posedge clk) disable iff (rst)
    commit |=> !nospec); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    nospec && !commit |=> nospec); // R7
endmodule

// File: rtl/psv_outreg.sv
module psv_outreg #(
  parameter int NUM_PRED = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PRED-1:0] n_dv,
  input  logic [NUM_PRED-1:0] n_dval,
  input  logic                n_mis,
  input  logic [IDX_W-1:0]    n_idx,
  input  logic                n_val,
  output logic [NUM_PRED-1:0] del_valid,
  output logic [NUM_PRED-1:0] del_value,
  output logic                flush_req,
  output logic                upd_valid,
  output logic [IDX_W-1:0]    upd_idx,
  output logic                upd_value
);
  always_ff @(posedge clk) begin
    if (rst) begin
      del_valid <= '0;
      del_value <= '0;
      flush_req <= 1'b0;
      upd_valid <= 1'b0;
      upd_idx   <= '0;
      upd_value <= 1'b0;
    end else begin
      del_valid <= n_dv;
      del_value <= n_dval & n_dv;
      flush_req <= n_mis;
      upd_valid <= n_mis;
      upd_idx   <= n_mis ? n_idx : '0;
      upd_value <= n_mis & n_val;
    end
  end

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !flush_req); // R5
  AST_NO_DOUBLE_DELIVERY: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> del_valid == '0); // R4
  AST_VALUE_MASKED: assert property (@(posedge clk) disable iff (rst)
    (del_value & ~del_valid) == '0); // R2
endmodule

// File: rtl/psv_unit.sv
module psv_unit #(
  parameter int NUM_PRED = 4,
  localparam int IDX_W = (NUM_PRED > 1) ? $clog2(NUM_PRED) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                blk_load,
  input  logic [NUM_PRED-1:0] load_pred,
  input  logic [NUM_PRED-1:0] load_conf,
  input  logic                res_valid,
  input  logic [IDX_W-1:0]    res_idx,
  input  logic                res_value,
  input  logic                blk_commit,
  input  logic                blk_flush,
  output logic [NUM_PRED-1:0] del_valid,
  output logic [NUM_PRED-1:0] del_value,
  output logic                flush_req,
  output logic                upd_valid,
  output logic [IDX_W-1:0]    upd_idx,
  output logic                upd_value,
  output logic                nospec_mode
);
  logic [NUM_PRED-1:0] loaded_v, pred_v, spec_v, done_v, hit_v, spec_in;
  logic [NUM_PRED-1:0] onehot, n_dv, n_dval;
  logic kill, load_go, res_go, mis_now, clr;
  logic sel_loaded, sel_pred, sel_spec, sel_done;

  assign kill    = blk_commit | blk_flush;
  assign load_go = blk_load & ~kill;
  assign spec_in = load_conf & {NUM_PRED{~nospec_mode}};

  always_comb begin
    sel_loaded = 1'b0;
    sel_pred   = 1'b0;
    sel_spec   = 1'b0;
    sel_done   = 1'b0;
    onehot     = '0;
    for (int k = 0; k < NUM_PRED; k++) begin
      if (res_idx == IDX_W'(k)) begin
        sel_loaded = loaded_v[k];
        sel_pred   = pred_v[k];
        sel_spec   = spec_v[k];
        sel_done   = done_v[k];
        onehot[k]  = 1'b1;
      end
    end
  end

  assign res_go  = res_valid & ~kill & ~blk_load & sel_loaded & ~sel_done;
  assign mis_now = res_go & sel_spec & (res_value != sel_pred);
  assign clr     = kill | mis_now;
  assign hit_v   = onehot & {NUM_PRED{res_go}};

  always_comb begin
    n_dv   = '0;
    n_dval = '0;
    if (load_go) begin
      n_dv   = spec_in;
      n_dval = load_pred & spec_in;
    end else if (res_go && !sel_spec) begin
      n_dv   = onehot;
      n_dval = onehot & {NUM_PRED{res_value}};
    end
  end

  for (genvar i = 0; i < NUM_PRED; i++) begin : g_slot
    psv_slot u_slot (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .ld      (load_go),
      .ld_pred (load_pred[i]),
      .ld_spec (spec_in[i]),
      .hit     (hit_v[i]),
      .loaded  (loaded_v[i]),
      .pred    (pred_v[i]),
      .spec    (spec_v[i]),
      .done    (done_v[i])
    );
  end

  psv_mode u_mode (
    .clk    (clk),
    .rst    (rst),
    .commit (blk_commit),
    .mis    (mis_now),
    .nospec (nospec_mode)
  );

  psv_outreg #(.NUM_PRED(NUM_PRED), .IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .n_dv      (n_dv),
    .n_dval    (n_dval),
    .n_mis     (mis_now),
    .n_idx     (res_idx),
    .n_val     (res_value),
    .del_valid (del_valid),
    .del_value (del_value),
    .flush_req (flush_req),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx),
    .upd_value (upd_value)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (del_valid == '0 && !flush_req && !upd_valid && !nospec_mode)); // R1
  AST_LOAD_ISSUES_TRUSTED: assert property (@(posedge clk) disable iff (rst)
    blk_load && !kill && !nospec_mode |=> del_valid == $past(load_conf)); // R2
  AST_SAFE_LOAD_SILENT: assert property (@(posedge clk) disable iff (rst)
    blk_load && !kill && nospec_mode |=> del_valid == '0); // R6
  AST_FLUSH_ENTERS_SAFE: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> nospec_mode); // R6
  AST_KILL_SILENCES: assert property (@(posedge clk) disable iff (rst)
    kill |=> (del_valid == '0 && !flush_req)); // R10
endmodule

// File: tb/psv_unit_bench.sv
module psv_unit_bench;
  localparam int NP = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst;
  logic blk_load, res_valid, res_value, blk_commit, blk_flush;
  logic [NP-1:0] load_pred, load_conf;
  logic [IW-1:0] res_idx;
  logic [NP-1:0] del_valid, del_value;
  logic flush_req, upd_valid, upd_value, nospec_mode;
  logic [IW-1:0] upd_idx;

  always #2 clk = ~clk;

  psv_unit #(.NUM_PRED(NP)) u_psv_unit (
    .clk(clk), .rst(rst), .blk_load(blk_load), .load_pred(load_pred),
    .load_conf(load_conf), .res_valid(res_valid), .res_idx(res_idx),
    .res_value(res_value), .blk_commit(blk_commit), .blk_flush(blk_flush),
    .del_valid(del_valid), .del_value(del_value), .flush_req(flush_req),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_value(upd_value),
    .nospec_mode(nospec_mode)
  );

  typedef struct {
    logic [NP-1:0] dv;
    logic [NP-1:0] dval;
    logic          fl;
    logic [IW-1:0] ui;
    logic          uv;
    logic          ns;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      logic [NP+NP+IW+2:0] act, exv;
      e = sb.pop_front();
      act = {del_valid, del_value, flush_req, upd_valid, upd_idx, upd_value};
      exv = {e.dv, e.dval, e.fl, e.fl, e.ui, e.uv};
      n_tests++;
      if (act !== exv || nospec_mode !== e.ns) begin
        n_fail++;
        $display("FAIL %s: got dv=%b dval=%b fl=%b uvld=%b ui=%0d uv=%b ns=%b, expected dv=%b dval=%b fl=%b ui=%0d uv=%b ns=%b",
                 e.tag, del_valid, del_value, flush_req, upd_valid, upd_idx, upd_value,
                 nospec_mode, e.dv, e.dval, e.fl, e.ui, e.uv, e.ns);
      end
    end
  end

  task automatic cyc(input logic ld, input logic [NP-1:0] p, input logic [NP-1:0] c,
                     input logic rv, input logic [IW-1:0] ri, input logic rval,
                     input logic cm, input logic fl,
                     input logic [NP-1:0] e_dv, input logic [NP-1:0] e_dval,
                     input logic e_fl, input logic [IW-1:0] e_ui, input logic e_uv,
                     input logic e_ns, input string tag);
    exp_t e;
    @(negedge clk);
    blk_load = ld; load_pred = p; load_conf = c;
    res_valid = rv; res_idx = ri; res_value = rval;
    blk_commit = cm; blk_flush = fl;
    e.dv = e_dv; e.dval = e_dval; e.fl = e_fl; e.ui = e_ui; e.uv = e_uv;
    e.ns = e_ns; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic res(input logic [IW-1:0] ri, input logic rval,
                     input logic [NP-1:0] e_dv, input logic [NP-1:0] e_dval,
                     input logic e_ns, input string tag);
    cyc(0, '0, '0, 1, ri, rval, 0, 0, e_dv, e_dval, 0, '0, 0, e_ns, tag);
  endtask

  task automatic load(input logic [NP-1:0] p, input logic [NP-1:0] c,
                      input logic [NP-1:0] e_dv, input logic [NP-1:0] e_dval,
                      input logic e_ns, input string tag);
    cyc(1, p, c, 0, '0, 0, 0, 0, e_dv, e_dval, 0, '0, 0, e_ns, tag);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    blk_load = 0; load_pred = '0; load_conf = '0; res_valid = 0;
    res_idx = '0; res_value = 0; blk_commit = 0; blk_flush = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc(0, '0, '0, 0, '0, 0, 0, 0, '0, '0, 0, '0, 0, 0, "R1 reset state");
    load(4'b0101, 4'b0011, 4'b0011, 4'b0001, 0, "R2 trusted issue");
    res(2'd0, 1, 4'b0000, 4'b0000, 0, "R4 matching trusted suppressed");
    res(2'd2, 0, 4'b0100, 4'b0000, 0, "R3 untrusted forwarded 0");
    res(2'd3, 1, 4'b1000, 4'b1000, 0, "R3 untrusted forwarded 1");
    res(2'd3, 0, 4'b0000, 4'b0000, 0, "R9 repeat outcome ignored");
    cyc(0, '0, '0, 1, 2'd1, 1, 0, 0, '0, '0, 1, 2'd1, 1, 1, "R5 mismatch flush");
    cyc(0, '0, '0, 0, '0, 0, 0, 0, '0, '0, 0, '0, 0, 1, "R7 safe mode held");
    res(2'd2, 1, 4'b0000, 4'b0000, 1, "R8 cleared after misspec");
    load(4'b1111, 4'b1111, 4'b0000, 4'b0000, 1, "R6 safe load silent");
    res(2'd0, 0, 4'b0001, 4'b0000, 1, "R6 safe mode forwards");
    cyc(0, '0, '0, 0, '0, 0, 1, 0, '0, '0, 0, '0, 0, 0, "R7 commit leaves safe mode");
    res(2'd1, 1, 4'b0000, 4'b0000, 0, "R8 cleared after commit");
    load(4'b0010, 4'b0110, 4'b0110, 4'b0010, 0, "R2 second pattern");
    cyc(1, 4'b1000, 4'b1000, 1, 2'd1, 0, 0, 0, 4'b1000, 4'b1000, 0, '0, 0, 0, "R10 load beats outcome");
    cyc(0, '0, '0, 1, 2'd3, 0, 0, 1, '0, '0, 0, '0, 0, 0, "R10 flush beats outcome");
    res(2'd3, 0, 4'b0000, 4'b0000, 0, "R8 cleared after flush");
    load(4'b0000, 4'b1111, 4'b1111, 4'b0000, 0, "R2 all trusted zeros");
    cyc(1, 4'b1111, 4'b1111, 0, '0, 0, 1, 0, '0, '0, 0, '0, 0, 0, "R10 commit beats load");
    res(2'd0, 1, 4'b0000, 4'b0000, 0, "R8 nothing after commit");
    load(4'b0001, 4'b0000, 4'b0000, 4'b0000, 0, "R2 no trusted bits");
    res(2'd0, 1, 4'b0001, 4'b0001, 0, "R3 forwarded after silent load");
    cyc(0, '0, '0, 0, '0, 0, 0, 0, '0, '0, 0, '0, 0, 0, "R1 idle quiet");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule